// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core may have its clock stopped and when that clock must come back. The core raises a one-cycle wait-for-interrupt or wait-for-event request. The block compares the request against a summary of interrupt state: a pending flag with the priority of the most urgent pending interrupt, the current execution priority, a global mask bit and a wake-on-pending control bit. It also takes a debug request with its enable bit, an external event line and a send-event pulse. From these it drives a clock-gate enable for the core, a sleeping status and a one-cycle wake pulse that marks the completion of every accepted wait.

If a wake condition already holds when a wait is issued, the wait completes as a no-op and the clock is never stopped. A one-bit event latch remembers events that arrive while the core is running. A later wait-for-event consumes the latch and returns at once. The block itself runs on the free-running clock, so it keeps watching for wake conditions while the core's clock is gated. Priority values compare numerically, and a lower value is more urgent.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset `clk_en` is 1, `sleeping` is 0, `wake` is 0 and the event latch is clear.
- R2: During a wait-for-interrupt, a pending interrupt with `pend_prio` < `cur_prio` ends the sleep whether or not `irq_mask` is set. A pending interrupt with `pend_prio` >= `cur_prio` does not end it.
- R3: During a wait-for-interrupt, `dbg_req` ends the sleep whatever the value of `dbg_en`. `ext_evt`, `sev_pulse` and the event latch have no effect on this wait.
- R4: If a wake condition for the requested wait holds in the cycle the request is sampled, the block asserts `wake` one cycle later, and `sleeping` and `clk_en` stay at 0 and 1.
- R5: A wait-for-event issued while the event latch is 1 completes immediately without sleeping, and it clears the latch.
- R6: A wait-for-event that sleeps ends only on one of these: a taken interrupt (`pend_prio` < `cur_prio` with `irq_mask` at 0); a rise of `pend_valid` while `wake_on_pend` is 1; `dbg_req` while `dbg_en` is 1; `ext_evt`; or `sev_pulse`.
- R7: The event latch is set by `ext_evt` or `sev_pulse` only while the core is awake. An event that ends a sleep does not set it.
- R8: `clk_en` changes only on the falling clock edge. At every rising edge it equals the inverse of `sleeping`.
- R9: `wake` is a one-cycle pulse. It is asserted in the cycle in which `sleeping` returns to 0, and it is never asserted while `sleeping` is 1.
- R10: A request sampled while sleeping is ignored. When `wfi_req` and `wfe_req` arrive together, only the wait-for-interrupt is accepted and the event latch is left unchanged.
- R11: `sleeping` rises only in the cycle after a request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt request, one cycle |
| wfe_req | input | 1 | Wait-for-event request, one cycle |
| pend_valid | input | 1 | At least one enabled interrupt is pending |
| pend_prio | input | PRIO_W | Priority of the most urgent pending interrupt |
| cur_prio | input | PRIO_W | Current execution priority |
| irq_mask | input | 1 | Global interrupt mask |
| wake_on_pend | input | 1 | A newly pending interrupt wakes a wait-for-event |
| dbg_req | input | 1 | Debug entry request |
| dbg_en | input | 1 | Debug enabled |
| ext_evt | input | 1 | External event |
| sev_pulse | input | 1 | Send-event pulse from the core |
| clk_en | output | 1 | Clock-gate enable for the core, changes on falling edge |
| sleeping | output | 1 | Core clock is stopped |
| wake | output | 1 | One-cycle completion pulse of a wait |

## Verification
A wrong sleep mode shows up as a wait that ends on the wrong source. For example, an event could end a wait-for-interrupt, or a masked interrupt could be ignored. The bench sees this as a wake pulse one cycle after the stimulus when it expected none, or as no pulse when it expected one. A corrupted event latch stays hidden until the next wait-for-event, which then either returns at once without sleeping or sleeps when it should not. A mismatch between the gate enable and the sleeping status is visible at the very next rising edge.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfi_req,
  input  logic              wfe_req,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              irq_mask,
  input  logic              wake_on_pend,
  input  logic              dbg_req,
  input  logic              dbg_en,
  input  logic              ext_evt,
  input  logic              sev_pulse,
  output logic              clk_en,
  output logic              sleeping,
  output logic              wake
);

  typedef enum logic [1:0] {AWAKE, NAP_WFI, NAP_WFE} mode_e;

  mode_e mode_q, mode_d;
  logic  evt_q, evt_d, pend_q, wake_q, done, gate_q;

  logic preempt, taken, pend_new, any_evt, wfi_wake, wfe_wake;
  logic awake, take_wfi, take_wfe;

  assign preempt  = pend_valid && (pend_prio < cur_prio);
  assign taken    = preempt && !irq_mask;
  assign pend_new = pend_valid && !pend_q;
  assign any_evt  = ext_evt || sev_pulse;
  assign wfi_wake = preempt || dbg_req;
  assign wfe_wake = taken || (wake_on_pend && pend_new) || (dbg_req && dbg_en) || any_evt;

  assign awake    = (mode_q == AWAKE);
  assign take_wfi = awake && wfi_req;
  assign take_wfe = awake && wfe_req && !wfi_req;

  always_comb begin
    mode_d = mode_q;
    done   = 1'b0;
    case (mode_q)
      AWAKE: begin
        if (take_wfi) begin
          if (wfi_wake) done = 1'b1;
          else          mode_d = NAP_WFI;
        end else if (take_wfe) begin
          if (evt_q || wfe_wake) done = 1'b1;
          else                   mode_d = NAP_WFE;
        end
      end
      NAP_WFI: if (wfi_wake) begin
        mode_d = AWAKE;
        done   = 1'b1;
      end
      NAP_WFE: if (wfe_wake) begin
        mode_d = AWAKE;
        done   = 1'b1;
      end
      default: mode_d = AWAKE;
    endcase
  end

  always_comb begin
    if (take_wfe)               evt_d = 1'b0;
    else if (awake && any_evt)  evt_d = 1'b1;
    else                        evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AWAKE;
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      evt_q  <= evt_d;
      pend_q <= pend_valid;
      wake_q <= done;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= awake;
  end

  assign clk_en   = gate_q;
  assign sleeping = !awake;
  assign wake     = wake_q;

endmodule

module sleep_wake_ctrl_chk #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wfi_req,
  input logic              wfe_req,
  input logic              pend_valid,
  input logic [PRIO_W-1:0] pend_prio,
  input logic [PRIO_W-1:0] cur_prio,
  input logic              irq_mask,
  input logic              dbg_req,
  input logic              dbg_en,
  input logic              clk_en,
  input logic              sleeping,
  input logic              wake
);

  // R8
  gate_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en == !sleeping);

  // R9
  wake_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !sleeping);

  // R9
  wake_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> wake);

  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(wfi_req || wfe_req));

  // R6
  dbg_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && dbg_req && dbg_en) |=> (!sleeping && wake));

  // R2
  taken_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && pend_valid && (pend_prio < cur_prio) && !irq_mask) |=> (!sleeping && wake));

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
  .pend_valid(pend_valid), .pend_prio(pend_prio), .cur_prio(cur_prio),
  .irq_mask(irq_mask), .dbg_req(dbg_req), .dbg_en(dbg_en),
  .clk_en(clk_en), .sleeping(sleeping), .wake(wake)
);

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n, wfi_req, wfe_req, pend_valid, irq_mask, wake_on_pend;
  logic dbg_req, dbg_en, ext_evt, sev_pulse;
  logic [PW-1:0] pend_prio, cur_prio;
  logic clk_en, sleeping, wake;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string tag_q[$];
  bit    slept_q[$];
  bit    slept_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl #(.PRIO_W(PW)) i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .pend_valid(pend_valid), .pend_prio(pend_prio), .cur_prio(cur_prio),
    .irq_mask(irq_mask), .wake_on_pend(wake_on_pend), .dbg_req(dbg_req),
    .dbg_en(dbg_en), .ext_evt(ext_evt), .sev_pulse(sev_pulse),
    .clk_en(clk_en), .sleeping(sleeping), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // driver: issue a wait, push the expected completion
  task automatic issue(input bit wi, input bit we, input bit push, input bit exp_slept, input string tag);
    if (push) begin
      tag_q.push_back(tag);
      slept_q.push_back(exp_slept);
    end
    wfi_req = wi; wfe_req = we;
    step();
    wfi_req = 0; wfe_req = 0;
  endtask

  // monitor: pops one expected completion per wake pulse
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (clk_en != !sleeping) chk(0, "R8 gate", clk_en, !sleeping);
        if (sleeping) slept_seen = 1;
        if (wake) begin
          if (tag_q.size() == 0) chk(0, "R9 unexpected wake", 1, 0);
          else begin
            string t;
            bit e;
            t = tag_q.pop_front();
            e = slept_q.pop_front();
            chk(slept_seen == e, t, slept_seen, e);
          end
          slept_seen = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wfi_req = 0; wfe_req = 0; pend_valid = 0; irq_mask = 0;
    wake_on_pend = 0; dbg_req = 0; dbg_en = 0; ext_evt = 0; sev_pulse = 0;
    pend_prio = 0; cur_prio = 4'd4;
    step(); step();
    chk(clk_en == 1 && sleeping == 0 && wake == 0, "R1 reset", {clk_en, sleeping, wake}, 3'b100);
    rst_n = 1;
    step();

    // R2 unmasked preempting interrupt
    issue(1, 0, 1, 1, "R2 wfi taken");
    chk(sleeping == 1, "R2 sleeps", sleeping, 1);
    pend_valid = 1; pend_prio = 4'd1;
    step();
    chk(wake == 1 && sleeping == 0, "R2 wake", wake, 1);
    pend_valid = 0;
    step();
    chk(wake == 0, "R9 one cycle", wake, 0);

    // R2 masked interrupt still wakes; not-higher priority does not
    irq_mask = 1;
    issue(1, 0, 1, 1, "R2 wfi masked");
    pend_valid = 1; pend_prio = 4'd4;
    step(); step();
    chk(sleeping == 1, "R2 equal prio stays", sleeping, 1);
    pend_prio = 4'd2;
    step();
    chk(wake == 1, "R2 masked wake", wake, 1);
    pend_valid = 0; irq_mask = 0;
    step();

    // R3 debug wakes wfi even when disabled
    issue(1, 0, 1, 1, "R3 wfi dbg");
    dbg_en = 0; dbg_req = 1;
    step();
    chk(wake == 1, "R3 dbg wake", wake, 1);
    dbg_req = 0;
    step();

    // R4 already pending -> no-op
    pend_valid = 1; pend_prio = 4'd0;
    issue(1, 0, 1, 0, "R4 wfi noop");
    chk(wake == 1 && sleeping == 0 && clk_en == 1, "R4 noop", {wake, sleeping, clk_en}, 3'b101);
    pend_valid = 0;
    step();

    // R7 latch set while awake, R5 consumed
    sev_pulse = 1; step(); sev_pulse = 0; step();
    issue(0, 1, 1, 0, "R5 wfe latch");
    chk(wake == 1 && sleeping == 0, "R5 immediate", wake, 1);
    step();
    issue(0, 1, 1, 1, "R5 latch cleared");
    chk(sleeping == 1, "R5 cleared sleeps", sleeping, 1);
    ext_evt = 1;
    step();
    chk(wake == 1, "R6 ext evt", wake, 1);
    ext_evt = 0;
    step();

    // R6 masked pending only with wake_on_pend
    irq_mask = 1;
    issue(0, 1, 1, 1, "R6 wfe pend");
    pend_valid = 1; pend_prio = 4'd1;
    step(); step();
    chk(sleeping == 1, "R6 masked no wake", sleeping, 1);
    pend_valid = 0; wake_on_pend = 1;
    step();
    pend_valid = 1;
    step();
    chk(wake == 1, "R6 pend wake", wake, 1);
    pend_valid = 0; wake_on_pend = 0; irq_mask = 0;
    step();

    // R6 debug needs enable
    issue(0, 1, 1, 1, "R6 wfe dbg");
    dbg_req = 1; dbg_en = 0;
    step(); step();
    chk(sleeping == 1, "R6 dbg disabled", sleeping, 1);
    dbg_en = 1;
    step();
    chk(wake == 1, "R6 dbg enabled", wake, 1);
    dbg_req = 0; dbg_en = 0;
    step();

    // R10/R3 ignored request and event during wfi; R7 latch not set
    issue(1, 0, 1, 1, "R10 wfi");
    wfe_req = 1; ext_evt = 1;
    step();
    wfe_req = 0; ext_evt = 0;
    step();
    chk(sleeping == 1 && wake == 0, "R3 event ignored", sleeping, 1);
    pend_valid = 1; pend_prio = 4'd1;
    step();
    chk(wake == 1, "R10 wake", wake, 1);
    pend_valid = 0;
    step(); step();
    issue(0, 1, 1, 1, "R7 latch empty");
    chk(sleeping == 1, "R7 no latch", sleeping, 1);
    sev_pulse = 1;
    step();
    chk(wake == 1, "R6 sev wake", wake, 1);
    sev_pulse = 0;
    step();

    // R10 simultaneous requests: WFI wins, latch kept
    ext_evt = 1; step(); ext_evt = 0; step();
    issue(1, 1, 1, 1, "R10 both");
    chk(sleeping == 1, "R10 wfi taken", sleeping, 1);
    dbg_req = 1;
    step();
    chk(wake == 1, "R10 dbg wake", wake, 1);
    dbg_req = 0;
    step();
    issue(0, 1, 1, 0, "R10 latch kept");
    chk(sleeping == 0, "R10 latch kept", sleeping, 0);
    step(); step();

    chk(tag_q.size() == 0, "R9 missing wake", tag_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule